// File: doc/BRIEF.md
# Programmable Sync Output Regenerator

This block sits behind a video input path and rebuilds the horizontal and vertical sync pulses. Each raw sync input has an input polarity. That polarity is either learned from the signal itself or set from a configuration bit. The block finds the leading edge of the active phase of each input and uses it to start a fresh output pulse. The pulse width comes from a programmed count, not from the input. Each output also has its own selectable active level.

The horizontal pulse width is counted in pixel clocks, with a reset default of 32. The vertical pulse width is counted in lines, meaning leading edges of the horizontal input, with a default of 4. The block also counts the lines in each frame and holds that count on a 12-bit output. The count is refreshed at every vertical leading edge, after which counting starts again from zero.

Top module: `sync_regen`

## Requirements
- R1: While reset is low and right after it is released, `hs_out` and `vs_out` sit at the inactive level set by their output polarity, and `line_count` reads 0.
- R2: When the horizontal input makes its transition into the active phase between two clock edges, the first rising edge samples it and `hs_out` goes active from the second rising edge on.
- R3: `hs_out` stays active for exactly `hs_width` clock cycles, whatever the input pulse width. A value of 0 produces no pulse.
- R4: Output polarity bits `hs_out_pol` and `vs_out_pol` choose the active level of their outputs: 1 means active high and 0 means active low.
- R5: With a force bit at 1, the matching manual bit sets the input polarity (1 = active high, 0 = active low). The leading edge is then the transition into that level, even when the real pulse has the other sense.
- R6: With a force bit at 0, the input polarity is learned. Each time a high phase ends after a complete low phase has been measured, the active level becomes high if that high phase was strictly shorter than the last low phase, and low otherwise. Before the first such decision, active high is assumed. A steady pulse train is settled after three periods.
- R7: `vs_out` goes active with the same two-edge timing as R2, counted from the vertical input's leading edge. It goes inactive at the clock edge where the `vs_width`-th following horizontal leading edge starts its `hs_out` pulse. A `vs_width` of 0 produces no pulse and ends a pulse already in progress.
- R8: At each vertical leading edge, `line_count` takes the number of horizontal leading edges seen since the previous vertical leading edge. It changes on the same edge at which `vs_out` would go active, holds between frames, and saturates at 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_in | input | 1 | Raw horizontal sync |
| vs_in | input | 1 | Raw vertical sync |
| hs_force | input | 1 | 1: horizontal input polarity from `hs_manual`; 0: learned |
| hs_manual | input | 1 | Manual horizontal input polarity, 1 = active high |
| vs_force | input | 1 | 1: vertical input polarity from `vs_manual`; 0: learned |
| vs_manual | input | 1 | Manual vertical input polarity, 1 = active high |
| hs_width | input | 8 | Output horizontal pulse width in clocks |
| vs_width | input | 8 | Output vertical pulse width in lines |
| hs_out_pol | input | 1 | Output horizontal active level, 1 = high |
| vs_out_pol | input | 1 | Output vertical active level, 1 = high |
| hs_out | output | 1 | Regenerated horizontal sync |
| vs_out | output | 1 | Regenerated vertical sync |
| line_count | output | 12 | Lines in the last complete frame |

## Verification
Zero and maximum horizontal widths are driven against a short input pulse. A design that copied the input width, or counted one clock too few or too many, would report the wrong width.

A manual polarity that disagrees with the real pulse is applied on purpose. Here the output must start three clocks later, at the trailing transition, and a design that ignored the force bit would start at the wrong edge. Learned polarity is exercised for both pulse senses, and for the default that applies before any decision.

On the vertical side, the bench checks the line on which the pulse ends, a zero width cutting a running pulse short, an empty frame, and the saturated count of 4095. A counter that wrapped would report a small number instead.

// File: rtl/sync_regen_pkg.sv
package sync_regen_pkg;
    localparam int unsigned DEF_HS_WIDTH = 32;
    localparam int unsigned DEF_VS_WIDTH = 4;

    typedef enum logic {
        POL_LOW  = 1'b0,
        POL_HIGH = 1'b1
    } pol_e;
endpackage

// File: rtl/sync_pol_detect.sv
module sync_pol_detect
    import sync_regen_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    input  logic force_pol,
    input  logic manual_pol,
    output logic lead,
    output logic level
);
    typedef struct packed {
        logic             smp;
        logic             act;
        logic [CNT_W-1:0] run;
        logic [CNT_W-1:0] lo_len;
        logic             lo_ok;
        pol_e             det;
    } det_st_t;

    det_st_t q, d;
    logic    pol_eff;
    logic    act_now;

    always_comb begin
        d     = q;
        d.smp = sig_in;
        if (sig_in != q.smp) begin
            d.run = CNT_W'(1);
            if (!q.smp) begin
                // a low phase just ended: remember its length
                d.lo_len = q.run;
                d.lo_ok  = 1'b1;
            end else if (q.lo_ok) begin
                // a high phase just ended: shorter phase is the active one
                d.det = (q.run < q.lo_len) ? POL_HIGH : POL_LOW;
            end
        end else if (q.run != '1) begin
            d.run = q.run + 1'b1;
        end
        pol_eff = force_pol ? manual_pol : (q.det == POL_HIGH);
        act_now = pol_eff ? q.smp : ~q.smp;
        d.act   = act_now;
        lead    = act_now & ~q.act;
        level   = act_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{smp: 1'b0, act: 1'b0, run: '0, lo_len: '0, lo_ok: 1'b0, det: POL_HIGH};
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen #(
    parameter int unsigned W_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           tick,
    input  logic [W_W-1:0] width,
    output logic           active
);
    typedef struct packed {
        logic           act;
        logic [W_W-1:0] left;
    } pg_st_t;

    pg_st_t q, d;

    always_comb begin
        d = q;
        if (start) begin
            d.act  = (width != '0);
            d.left = width;
        end else if (q.act && tick) begin
            if (q.left <= W_W'(1)) begin
                d.act  = 1'b0;
                d.left = '0;
            end else begin
                d.left = q.left - 1'b1;
            end
        end
        active = q.act;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{act: 1'b0, left: '0};
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/sync_line_counter.sv
module sync_line_counter #(
    parameter int unsigned LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_evt,
    input  logic              frame_evt,
    output logic [LINE_W-1:0] lines
);
    typedef struct packed {
        logic [LINE_W-1:0] run;
        logic [LINE_W-1:0] held;
    } lc_st_t;

    lc_st_t q, d;

    always_comb begin
        d = q;
        if (frame_evt) begin
            d.held = q.run;
            d.run  = line_evt ? LINE_W'(1) : '0;
        end else if (line_evt && (q.run != '1)) begin
            d.run = q.run + 1'b1;
        end
        lines = q.held;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{run: '0, held: '0};
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/sync_regen.sv
module sync_regen
    import sync_regen_pkg::*;
#(
    parameter int unsigned HW_W   = 8,
    parameter int unsigned VW_W   = 8,
    parameter int unsigned LINE_W = 12,
    parameter int unsigned DET_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_in,
    input  logic              vs_in,
    input  logic              hs_force,
    input  logic              hs_manual,
    input  logic              vs_force,
    input  logic              vs_manual,
    input  logic [HW_W-1:0]   hs_width,
    input  logic [VW_W-1:0]   vs_width,
    input  logic              hs_out_pol,
    input  logic              vs_out_pol,
    output logic              hs_out,
    output logic              vs_out,
    output logic [LINE_W-1:0] line_count
);
    localparam int unsigned NCH = 2;
    localparam int unsigned CH_H = 0;
    localparam int unsigned CH_V = 1;

    logic [NCH-1:0] raw_in;
    logic [NCH-1:0] frc;
    logic [NCH-1:0] man;
    logic [NCH-1:0] lead_v;
    logic [NCH-1:0] level_v;
    logic           hs_lead;
    logic           vs_lead;
    logic           hs_act;
    logic           vs_act;

    assign raw_in = {vs_in, hs_in};
    assign frc    = {vs_force, hs_force};
    assign man    = {vs_manual, hs_manual};

    for (genvar c = 0; c < NCH; c++) begin : g_det
        sync_pol_detect #(.CNT_W(DET_W)) u_det (
            .clk       (clk),
            .rst_n     (rst_n),
            .sig_in    (raw_in[c]),
            .force_pol (frc[c]),
            .manual_pol(man[c]),
            .lead      (lead_v[c]),
            .level     (level_v[c])
        );
    end

    assign hs_lead = lead_v[CH_H];
    assign vs_lead = lead_v[CH_V];

    sync_pulse_gen #(.W_W(HW_W)) u_hs_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .start (hs_lead),
        .tick  (1'b1),
        .width (hs_width),
        .active(hs_act)
    );

    sync_pulse_gen #(.W_W(VW_W)) u_vs_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .start (vs_lead),
        .tick  (hs_lead),
        .width (vs_width),
        .active(vs_act)
    );

    sync_line_counter #(.LINE_W(LINE_W)) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_evt (hs_lead),
        .frame_evt(vs_lead),
        .lines    (line_count)
    );

    assign hs_out = hs_out_pol ? hs_act : ~hs_act;
    assign vs_out = vs_out_pol ? vs_act : ~vs_act;
endmodule

// File: rtl/sync_regen_chk.sv
module sync_regen_chk #(
    parameter int unsigned HW_W   = 8,
    parameter int unsigned VW_W   = 8,
    parameter int unsigned LINE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hs_lead,
    input logic              vs_lead,
    input logic              hs_out,
    input logic              vs_out,
    input logic              hs_out_pol,
    input logic              vs_out_pol,
    input logic [HW_W-1:0]   hs_width,
    input logic [VW_W-1:0]   vs_width,
    input logic [LINE_W-1:0] line_count
);
    logic hs_on;
    logic vs_on;
    assign hs_on = (hs_out == hs_out_pol);
    assign vs_on = (vs_out == vs_out_pol);

    AST_HS_START_AFTER_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_on && !$past(hs_on) && $stable(hs_out_pol)) |-> $past(hs_lead)); // R2

    AST_HS_ZERO_WIDTH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(hs_width) == '0) && $stable(hs_out_pol)) |-> !(hs_on && !$past(hs_on))); // R3

    AST_VS_START_AFTER_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_on && !$past(vs_on) && $stable(vs_out_pol)) |-> $past(vs_lead)); // R7

    AST_VS_END_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (!vs_on && $past(vs_on) && $stable(vs_out_pol)) |-> ($past(hs_lead) || $past(vs_lead))); // R7

    AST_COUNT_ONLY_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(vs_lead) |-> $stable(line_count)); // R8
endmodule

bind sync_regen sync_regen_chk #(.HW_W(HW_W), .VW_W(VW_W), .LINE_W(LINE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hs_lead   (hs_lead),
    .vs_lead   (vs_lead),
    .hs_out    (hs_out),
    .vs_out    (vs_out),
    .hs_out_pol(hs_out_pol),
    .vs_out_pol(vs_out_pol),
    .hs_width  (hs_width),
    .vs_width  (vs_width),
    .line_count(line_count)
);

// File: tb/test_sync_regen.sv
module test_sync_regen;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;
    // {hs_width[7:0], out_pol, force, manual, input active level}
    localparam logic [11:0] VEC [NVEC] = '{
        {8'd32,  4'b1111},
        {8'd5,   4'b0111},
        {8'd1,   4'b1100},
        {8'd0,   4'b1111},
        {8'd255, 4'b1100},
        {8'd4,   4'b1110},
        {8'd7,   4'b0101}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        hs_in, vs_in;
    logic        hs_force, hs_manual, vs_force, vs_manual;
    logic [7:0]  hs_width, vs_width;
    logic        hs_out_pol, vs_out_pol;
    logic        hs_out, vs_out;
    logic [11:0] line_count;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_regen i_sync_regen (
        .clk       (clk),
        .rst_n     (rst_n),
        .hs_in     (hs_in),
        .vs_in     (vs_in),
        .hs_force  (hs_force),
        .hs_manual (hs_manual),
        .vs_force  (vs_force),
        .vs_manual (vs_manual),
        .hs_width  (hs_width),
        .vs_width  (vs_width),
        .hs_out_pol(hs_out_pol),
        .vs_out_pol(vs_out_pol),
        .hs_out    (hs_out),
        .vs_out    (vs_out),
        .line_count(line_count)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive one input pulse and measure the start delay and width of hs_out
    task automatic send_hs(input logic lvl, input int in_len, output int dly, output int wid);
        dly = -1;
        wid = 0;
        hs_in = lvl;
        for (int i = 1; i <= 400; i++) begin
            @(negedge clk);
            if (i == in_len) hs_in = ~lvl;
            if (hs_out == hs_out_pol) begin
                if (dly < 0) dly = i;
                wid++;
            end
        end
    endtask

    task automatic run_periods(input logic lvl, input int act_len, input int idle_len, input int n);
        for (int p = 0; p < n; p++) begin
            hs_in = lvl;
            repeat (act_len) @(negedge clk);
            hs_in = ~lvl;
            repeat (idle_len) @(negedge clk);
        end
    endtask

    task automatic hs_tick(input int gap);
        hs_in = 1'b1;
        @(negedge clk);
        hs_in = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int dly, wid, exp_w, exp_d;
        rst_n = 1'b0;
        hs_in = 1'b0; vs_in = 1'b0;
        hs_force = 1'b0; hs_manual = 1'b1;
        vs_force = 1'b0; vs_manual = 1'b1;
        hs_width = 8'd32; vs_width = 8'd4;
        hs_out_pol = 1'b1; vs_out_pol = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 hs_out in reset", int'(hs_out), 0);
        chk("R1 vs_out in reset", int'(vs_out), 0);
        chk("R1 line_count in reset", int'(line_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 hs_out after reset", int'(hs_out), 0);
        chk("R1 line_count after reset", int'(line_count), 0);

        // R6: before any decision, active high is assumed
        repeat (10) @(negedge clk);
        send_hs(1'b1, 3, dly, wid);
        chk("R6 default polarity start delay", dly, 2);
        chk("R6 default width", wid, 32);

        // vector walk: R2 R3 R4 R5
        for (int k = 0; k < NVEC; k++) begin
            hs_width   = VEC[k][11:4];
            hs_out_pol = VEC[k][3];
            hs_force   = VEC[k][2];
            hs_manual  = VEC[k][1];
            hs_in      = ~VEC[k][0];
            repeat (300) @(negedge clk);
            send_hs(VEC[k][0], 3, dly, wid);
            exp_w = int'(VEC[k][11:4]);
            exp_d = (exp_w == 0) ? -1 : ((VEC[k][1] == VEC[k][0]) ? 2 : 5);
            chk($sformatf("R2/R5 start delay vec %0d", k), dly, exp_d);
            chk($sformatf("R3/R4 width vec %0d", k), wid, exp_w);
        end

        // R6: learned polarity, active-low train then active-high train
        hs_force = 1'b0; hs_width = 8'd6; hs_out_pol = 1'b1;
        hs_in = 1'b1;
        repeat (50) @(negedge clk);
        run_periods(1'b0, 4, 40, 4);
        send_hs(1'b0, 4, dly, wid);
        chk("R6 learned active low delay", dly, 2);
        chk("R6 learned active low width", wid, 6);
        hs_in = 1'b0;
        repeat (50) @(negedge clk);
        run_periods(1'b1, 4, 40, 4);
        send_hs(1'b1, 4, dly, wid);
        chk("R6 learned active high delay", dly, 2);
        chk("R6 learned active high width", wid, 6);

        // vertical path: R7 R8
        hs_force = 1'b1; hs_manual = 1'b1; hs_width = 8'd4; hs_in = 1'b0;
        vs_force = 1'b1; vs_manual = 1'b1; vs_width = 8'd3; vs_in = 1'b0;
        repeat (50) @(negedge clk);
        vs_in = 1'b1;
        @(negedge clk);
        chk("R7 vs not yet active", int'(vs_out), 0);
        @(negedge clk);
        chk("R7 vs active second edge", int'(vs_out), 1);
        vs_in = 1'b0;
        repeat (10) @(negedge clk);
        hs_tick(10);
        hs_tick(10);
        chk("R7 vs active after two lines", int'(vs_out), 1);
        hs_tick(10);
        chk("R7 vs ended after third line", int'(vs_out), 0);
        hs_tick(10);
        hs_tick(10);
        vs_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R8 five lines counted", int'(line_count), 5);
        vs_in = 1'b0;
        repeat (10) @(negedge clk);
        hs_tick(10);
        hs_tick(10);
        vs_in = 1'b1;
        @(negedge clk);
        chk("R8 count held until update edge", int'(line_count), 5);
        @(negedge clk);
        chk("R8 two lines counted", int'(line_count), 2);
        vs_in = 1'b0;
        repeat (10) @(negedge clk);
        vs_width = 8'd0;
        vs_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R8 empty frame", int'(line_count), 0);
        vs_in = 1'b0;
        repeat (5) @(negedge clk);
        chk("R7 zero width ends pulse", int'(vs_out), 0);

        // R8 saturation
        for (int j = 0; j < 4100; j++) hs_tick(2);
        vs_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R8 saturated count", int'(line_count), 4095);
        vs_in = 1'b0;
        repeat (10) @(negedge clk);

        // R4 vertical output active low
        vs_width = 8'd1; vs_out_pol = 1'b0;
        repeat (5) @(negedge clk);
        vs_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R4 vs active low", int'(vs_out), 0);
        vs_in = 1'b0;
        repeat (5) @(negedge clk);
        hs_tick(10);
        chk("R4 vs back to inactive high", int'(vs_out), 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule